// File: doc/BRIEF.md
# Display RAM Write Address Controller

This block tracks where the next byte goes in the display RAM of a matrix LCD driver. The RAM has 128 columns and six byte-wide banks. Banks 0 to 4 hold pixel data and bank 5 holds icon segments. A host-side front end turns bus traffic into two kinds of strobe. A command strobe carries an opcode and an argument. A data strobe carries one byte. The block turns each accepted data strobe into a registered RAM write, which gives the bank, the column and the byte. It then moves the pointer on, either along the columns (horizontal) or down the banks (vertical).

The block also holds the mode settings that the display side reads: power-down, the multiplex rate and the display-control bits. The pointer-advance rule is organised as three named stepping modes, chosen each cycle from the current bank and the direction bit:
- `AM_HORIZ`: a pixel bank with the direction bit at 0.
- `AM_VERT`: a pixel bank with the direction bit at 1.
- `AM_ICON`: bank 5, whatever the direction bit is.

The stepping modes have these transitions:
- The pointer leaves `AM_ICON` only through a set-bank command.
- It enters `AM_ICON` only through a set-bank command with code 5.
- A function-set command moves it between `AM_HORIZ` and `AM_VERT`.

Top module: `dram_wr_addr`

The command opcodes on `cmd_op` are:
- 0: set column, using `cmd_arg[6:0]`.
- 1: set bank, using `cmd_arg[2:0]`.
- 2: function set, with `cmd_arg[0]` as the direction bit (1 = vertical) and `cmd_arg[1]` as power-down.
- 3: multiplex rate, with `cmd_arg[1]` as M1 and `cmd_arg[0]` as M0.
- 4: display control, with `cmd_arg[0]` as E, `cmd_arg[1]` as D and `cmd_arg[2]` as icon mode.

Opcodes 5 to 7 do nothing.

## Requirements
- R1: After reset the column and the bank are both 0. The direction bit is 0 and power-down is 1, so `disp_on` is 0. `mux_rate` is 0, which means 1:17. `disp_mode` is 00 and `icon_mode` is 0. `ram_we` is 0.
- R2: Horizontal stepping in a pixel bank:
  - Each write raises the column by 1 and leaves the bank as it is.
  - From column 127 the column returns to 0 and the bank goes up by 1.
  - From bank 4 the bank returns to 0.
- R3: Vertical stepping in a pixel bank:
  - Each write raises the bank by 1 and leaves the column as it is.
  - From bank 4 the bank returns to 0 and the column goes up by 1.
  - From column 127 the column returns to 0.
- R4: In bank 5, each write raises the column by 1, from 127 back to 0. The bank stays at 5 for either value of the direction bit.
- R5: Set column (opcode 0) loads `cmd_arg[6:0]` into the column. Set bank (opcode 1) loads codes 0 to 5. Bank codes 6 and 7 leave the bank as it was.
- R6: A data strobe accepted in cycle N produces `ram_we` = 1 in cycle N+1, for that one cycle only. In the same cycle `ram_bank`, `ram_col` and `ram_wdata` carry the pointer from before the step and the byte that was written. These three outputs hold their values while `ram_we` is 0.
- R7: Opcode 3 decodes M1M0 as follows, and code 11 leaves the rate as it was:

  | M1M0 | Rate | `mux_rate` |
  |---|---|---|
  | 00 | 1:17 | 0 |
  | 10 | 1:26 | 1 |
  | 01 | 1:34 | 2 |

- R8: While power-down is 1, `disp_on` is 0 and data strobes are still written and stepped. The settings do not change unless a command changes them. `disp_on` equals the inverse of `pwr_down`.
- R9: Opcode 4 latches D and E into `disp_mode` as {D,E} and latches the icon-mode bit into `icon_mode`. Both keep their values until the next opcode 4.
- R10: When a command strobe and a data strobe arrive in the same cycle, the command is applied and the data strobe is dropped: no write happens and the pointer does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_arg | input | 7 | Command argument |
| wr_valid | input | 1 | Data-write strobe |
| wr_data | input | 8 | Byte to write |
| ram_we | output | 1 | RAM write enable, one cycle per write |
| ram_bank | output | 3 | Bank index of the write |
| ram_col | output | 7 | Column index of the write |
| ram_wdata | output | 8 | Byte for the RAM |
| pwr_down | output | 1 | Power-down flag |
| disp_on | output | 1 | Display enable, low in power-down |
| mux_rate | output | 2 | Multiplex rate: 0 is 1:17, 1 is 1:26, 2 is 1:34 |
| disp_mode | output | 2 | Display mode {D,E} |
| icon_mode | output | 1 | Icon-mode bit |

## Verification
The bench aims at the double wraps, where the last column meets the last pixel bank in both directions. A design that got these wrong would land in bank 5 or stay at column 127. The bench also writes in the icon bank with vertical mode selected, where a faulty design would leave the icon bank. It then sends the illegal bank codes and multiplex code, which a faulty design would load. Further checks cover:
- Bytes written during power-down, which would be lost if power-down gated the writes.
- A command and a data strobe in the same cycle, which a faulty design would let collide on the pointer.
- A long mixed stream of writes and commands, checked every clock against the model.

// File: rtl/lcdaddr_pkg.sv
package lcdaddr_pkg;

    typedef enum logic [2:0] {
        OP_SET_COL  = 3'd0,
        OP_SET_BANK = 3'd1,
        OP_FUNC     = 3'd2,
        OP_MUX      = 3'd3,
        OP_DISP     = 3'd4
    } cmd_op_e;

    typedef enum logic [1:0] {
        MUX_17 = 2'd0,
        MUX_26 = 2'd1,
        MUX_34 = 2'd2
    } mux_e;

    typedef enum logic [1:0] {
        AM_HORIZ = 2'd0,
        AM_VERT  = 2'd1,
        AM_ICON  = 2'd2
    } step_mode_e;

    typedef struct packed {
        logic set_col;
        logic set_bank;
        logic func;
        logic mux;
        logic disp;
    } cmd_strobe_t;

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
    import lcdaddr_pkg::*;
(
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    output cmd_strobe_t strobe
);

    always_comb begin
        strobe = '0;
        if (cmd_valid) begin
            unique case (cmd_op_e'(cmd_op))
                OP_SET_COL:  strobe.set_col  = 1'b1;
                OP_SET_BANK: strobe.set_bank = 1'b1;
                OP_FUNC:     strobe.func     = 1'b1;
                OP_MUX:      strobe.mux      = 1'b1;
                OP_DISP:     strobe.disp     = 1'b1;
                default:     strobe          = '0;
            endcase
        end
    end

    always_comb begin
        assert ($onehot0(strobe)); // R5
    end

endmodule

// File: rtl/mode_regs.sv
module mode_regs
    import lcdaddr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  cmd_strobe_t strobe,
    input  logic [2:0]  arg,
    output logic        vert,
    output logic        pd,
    output logic [1:0]  mux_rate,
    output logic [1:0]  disp_mode,
    output logic        icon_mode
);

    mux_e mux_q, mux_d;
    logic vert_q, pd_q, d_q, e_q, im_q;

    always_comb begin
        mux_d = mux_q;
        unique case (arg[1:0])
            2'b00:   mux_d = MUX_17;
            2'b10:   mux_d = MUX_26;
            2'b01:   mux_d = MUX_34;
            default: mux_d = mux_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vert_q <= 1'b0;
            pd_q   <= 1'b1;
            mux_q  <= MUX_17;
            d_q    <= 1'b0;
            e_q    <= 1'b0;
            im_q   <= 1'b0;
        end else begin
            if (strobe.func) begin
                vert_q <= arg[0];
                pd_q   <= arg[1];
            end
            if (strobe.mux) mux_q <= mux_d;
            if (strobe.disp) begin
                e_q  <= arg[0];
                d_q  <= arg[1];
                im_q <= arg[2];
            end
        end
    end

    assign vert      = vert_q;
    assign pd        = pd_q;
    assign mux_rate  = mux_q;
    assign disp_mode = {d_q, e_q};
    assign icon_mode = im_q;

    AST_MUX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mux_rate != 2'b11); // R7
    AST_MUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe.mux |=> $stable(mux_rate)); // R8
    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe.disp |=> $stable(disp_mode) && $stable(icon_mode)); // R9

endmodule

// File: rtl/addr_stepper.sv
module addr_stepper
    import lcdaddr_pkg::*;
#(
    parameter int NUM_COLS  = 128,
    parameter int PIX_BANKS = 5,
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int BANK_W   = $clog2(PIX_BANKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_col,
    input  logic              load_bank,
    input  logic [COL_W-1:0]  col_arg,
    input  logic [BANK_W-1:0] bank_arg,
    input  logic              step,
    input  logic              vert,
    output logic [COL_W-1:0]  col,
    output logic [BANK_W-1:0] bank
);

    localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(NUM_COLS - 1);
    localparam logic [BANK_W-1:0] ICON_BANK = BANK_W'(PIX_BANKS);
    localparam logic [BANK_W-1:0] PIX_LAST  = BANK_W'(PIX_BANKS - 1);

    logic [COL_W-1:0]  col_q, col_d, col_inc;
    logic [BANK_W-1:0] bank_q, bank_d, bank_inc;
    step_mode_e        mode;

    always_comb begin
        if (bank_q == ICON_BANK) mode = AM_ICON;
        else if (vert)           mode = AM_VERT;
        else                     mode = AM_HORIZ;
    end

    assign col_inc  = (col_q == COL_LAST) ? '0 : col_q + 1'b1;
    assign bank_inc = (bank_q == PIX_LAST) ? '0 : bank_q + 1'b1;

    always_comb begin
        col_d  = col_q;
        bank_d = bank_q;
        if (load_col) begin
            col_d = col_arg;
        end else if (load_bank) begin
            if (bank_arg <= ICON_BANK) bank_d = bank_arg;
        end else if (step) begin
            unique case (mode)
                AM_HORIZ: begin
                    col_d = col_inc;
                    if (col_q == COL_LAST) bank_d = bank_inc;
                end
                AM_VERT: begin
                    bank_d = bank_inc;
                    if (bank_q == PIX_LAST) col_d = col_inc;
                end
                AM_ICON: col_d = col_inc;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= '0;
            bank_q <= '0;
        end else begin
            col_q  <= col_d;
            bank_q <= bank_d;
        end
    end

    assign col  = col_q;
    assign bank = bank_q;

    AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bank <= ICON_BANK); // R5
    AST_HORIZ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load_col && !load_bank && !vert && bank < ICON_BANK && col != COL_LAST
        |=> col == $past(col) + 1'b1 && $stable(bank)); // R2
    AST_VERT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load_col && !load_bank && vert && bank < PIX_LAST
        |=> bank == $past(bank) + 1'b1 && $stable(col)); // R3
    AST_ICON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load_bank && bank == ICON_BANK |=> bank == ICON_BANK); // R4

endmodule

// File: rtl/dram_wr_addr.sv
module dram_wr_addr
    import lcdaddr_pkg::*;
#(
    parameter int NUM_COLS  = 128,
    parameter int PIX_BANKS = 5,
    parameter int DATA_W    = 8,
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int BANK_W   = $clog2(PIX_BANKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [COL_W-1:0]  cmd_arg,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ram_we,
    output logic [BANK_W-1:0] ram_bank,
    output logic [COL_W-1:0]  ram_col,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              pwr_down,
    output logic              disp_on,
    output logic [1:0]        mux_rate,
    output logic [1:0]        disp_mode,
    output logic              icon_mode
);

    cmd_strobe_t       strobe;
    logic              wr_ok, vert, pd;
    logic [COL_W-1:0]  col;
    logic [BANK_W-1:0] bank;

    assign wr_ok = wr_valid && !cmd_valid;

    cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .strobe    (strobe)
    );

    mode_regs u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .arg       (cmd_arg[2:0]),
        .vert      (vert),
        .pd        (pd),
        .mux_rate  (mux_rate),
        .disp_mode (disp_mode),
        .icon_mode (icon_mode)
    );

    addr_stepper #(
        .NUM_COLS  (NUM_COLS),
        .PIX_BANKS (PIX_BANKS)
    ) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_col  (strobe.set_col),
        .load_bank (strobe.set_bank),
        .col_arg   (cmd_arg),
        .bank_arg  (cmd_arg[BANK_W-1:0]),
        .step      (wr_ok),
        .vert      (vert),
        .col       (col),
        .bank      (bank)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_bank  <= '0;
            ram_col   <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= wr_ok;
            if (wr_ok) begin
                ram_bank  <= bank;
                ram_col   <= col;
                ram_wdata <= wr_data;
            end
        end
    end

    assign pwr_down = pd;
    assign disp_on  = ~pd;

    AST_WR_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !cmd_valid |=> ram_we && ram_wdata == $past(wr_data)); // R6
    AST_CMD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !ram_we); // R10
    AST_WR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> ram_bank == $past(bank) && ram_col == $past(col)); // R6

endmodule

// File: tb/dram_wr_addr_test.sv
`timescale 1ns/1ps
module dram_wr_addr_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [6:0] cmd_arg = '0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ram_we, pwr_down, disp_on, icon_mode;
    logic [2:0] ram_bank;
    logic [6:0] ram_col;
    logic [7:0] ram_wdata;
    logic [1:0] mux_rate, disp_mode;

    always #4 clk = ~clk;

    dram_wr_addr uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .wr_valid(wr_valid), .wr_data(wr_data),
        .ram_we(ram_we), .ram_bank(ram_bank), .ram_col(ram_col),
        .ram_wdata(ram_wdata), .pwr_down(pwr_down), .disp_on(disp_on),
        .mux_rate(mux_rate), .disp_mode(disp_mode), .icon_mode(icon_mode)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    int m_col, m_bank, m_v, m_pd, m_mux, m_d, m_e, m_im;
    int x_we, x_bank, x_col, x_data;
    int wr_log[$];

    task automatic model_reset();
        m_col = 0; m_bank = 0; m_v = 0; m_pd = 1; m_mux = 0;
        m_d = 0; m_e = 0; m_im = 0;
        x_we = 0; x_bank = 0; x_col = 0; x_data = 0;
    endtask

    task automatic model_step(input int cv, input int op, input int arg,
                              input int wv, input int data);
        x_we = 0;
        if (cv != 0) begin
            case (op)
                0: m_col = arg % 128;
                1: if ((arg % 8) <= 5) m_bank = arg % 8;
                2: begin m_v = arg % 2; m_pd = (arg / 2) % 2; end
                3: case (arg % 4)
                       0: m_mux = 0;
                       2: m_mux = 1;
                       1: m_mux = 2;
                       default: ;
                   endcase
                4: begin m_e = arg % 2; m_d = (arg / 2) % 2; m_im = (arg / 4) % 2; end
                default: ;
            endcase
        end else if (wv != 0) begin
            x_we = 1; x_bank = m_bank; x_col = m_col; x_data = data;
            wr_log.push_back(data);
            if (m_bank == 5) m_col = (m_col + 1) % 128;
            else if (m_v == 0) begin
                if (m_col == 127) begin m_col = 0; m_bank = (m_bank + 1) % 5; end
                else m_col++;
            end else begin
                if (m_bank == 4) begin m_bank = 0; m_col = (m_col + 1) % 128; end
                else m_bank++;
            end
        end
    endtask

    task automatic check(input string req);
        vectors++;
        if (ram_we !== 1'(x_we) || ram_bank !== 3'(x_bank) || ram_col !== 7'(x_col) ||
            ram_wdata !== 8'(x_data) || pwr_down !== 1'(m_pd) || disp_on !== 1'(1 - m_pd) ||
            mux_rate !== 2'(m_mux) || disp_mode !== 2'({m_d[0], m_e[0]}) ||
            icon_mode !== 1'(m_im)) begin
            fails++;
            $display("FAIL %s: got we=%0d bank=%0d col=%0d data=%0h pd=%0d on=%0d mux=%0d mode=%0d im=%0d; expected we=%0d bank=%0d col=%0d data=%0h pd=%0d on=%0d mux=%0d mode=%0d im=%0d",
                     req, ram_we, ram_bank, ram_col, ram_wdata, pwr_down, disp_on,
                     mux_rate, disp_mode, icon_mode, x_we, x_bank, x_col, x_data,
                     m_pd, 1 - m_pd, m_mux, m_d * 2 + m_e, m_im);
        end
    endtask

    // drive at a falling edge, let the rising edge act, compare at the next falling edge
    task automatic step(input string req, input int cv, input int op, input int arg,
                        input int wv, input int data);
        cmd_valid = 1'(cv); cmd_op = 3'(op); cmd_arg = 7'(arg);
        wr_valid = 1'(wv); wr_data = 8'(data);
        model_step(cv, op, arg, wv, data);
        @(negedge clk);
        check(req);
    endtask

    task automatic cmd(input string req, input int op, input int arg);
        step(req, 1, op, arg, 0, 0);
    endtask

    task automatic wr(input string req, input int data);
        step(req, 0, 0, 0, 1, data);
    endtask

    task automatic idle(input string req);
        step(req, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1");                         // R1 reset state under reset
        rst_n = 1'b1;
        idle("R1");
        idle("R1");

        // R2 horizontal, crossing the last column and the last pixel bank
        cmd("R5", 0, 126);
        cmd("R5", 1, 4);
        wr("R2", 8'h11); wr("R2", 8'h22); wr("R2", 8'h33); idle("R6");
        cmd("R5", 0, 127); cmd("R5", 1, 1);
        wr("R2", 8'h44); wr("R2", 8'h45);

        // R3 vertical, bank wrap with column step and column wrap
        cmd("R3", 2, 1);
        cmd("R5", 1, 3); cmd("R5", 0, 127);
        wr("R3", 8'h51); wr("R3", 8'h52); wr("R3", 8'h53); wr("R3", 8'h54);
        cmd("R5", 0, 10);
        for (int i = 0; i < 6; i++) wr("R3", 8'h60 + i);

        // R4 icon bank in both directions
        cmd("R5", 1, 5); cmd("R5", 0, 126);
        wr("R4", 8'hA1); wr("R4", 8'hA2); wr("R4", 8'hA3);
        cmd("R4", 2, 0);
        cmd("R5", 0, 127);
        wr("R4", 8'hA4); wr("R4", 8'hA5);

        // R5 illegal bank codes ignored, then a write shows the pointer
        cmd("R5", 1, 2);
        cmd("R5", 1, 6); wr("R5", 8'hB6);
        cmd("R5", 1, 7); wr("R5", 8'hB7);

        // R7 multiplex decode
        cmd("R7", 3, 2'b10); cmd("R7", 3, 2'b11); idle("R7");
        cmd("R7", 3, 2'b01); cmd("R7", 3, 2'b00); cmd("R7", 3, 2'b01);

        // R9 display control
        cmd("R9", 4, 3'b101); idle("R9");
        cmd("R9", 4, 3'b010); cmd("R9", 4, 3'b111);

        // R8 power-down keeps writes and settings
        cmd("R8", 2, 2'b10);
        wr("R8", 8'hC1); wr("R8", 8'hC2); idle("R8");
        cmd("R8", 2, 2'b00); idle("R8");
        cmd("R8", 2, 2'b11); wr("R8", 8'hC3);

        // R10 simultaneous command and write
        step("R10", 1, 0, 40, 1, 8'hD0);
        wr("R10", 8'hD1);
        step("R10", 1, 1, 6, 1, 8'hD2);
        step("R10", 1, 7, 0, 1, 8'hD3);
        wr("R10", 8'hD4);

        // mixed stream
        seed = 32'h1234_5678;
        for (int i = 0; i < 2000; i++) begin
            int r;
            seed = seed * 1103515245 + 12345;
            r = (seed >>> 8) & 32'h7FFF_FFFF;
            if (r % 10 < 7) wr("R6", r % 256);
            else if (r % 10 == 7) step("R10", 1, (r / 16) % 8, (r / 256) % 128, 1, r % 256);
            else cmd("R2", (r / 16) % 8, (r / 256) % 128);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule